// File: doc/BRIEF.md
# Windowed Register File

This block is a general-purpose register store of 64 entries, 16 bits each, that an instruction sees only through a movable window of four architectural registers, R0 to R3. A 6-bit window pointer holds the physical index of R0, and R1, R2 and R3 are the three entries that follow it, with the index wrapping modulo 64. Moving the pointer gives a routine or a task a fresh set of four registers without copying any data.

Two 2-bit selects taken from the instruction name a destination register and a source register. Both are read at the same time on two combinational read ports. The destination register is also the target of the single write port. The pointer can be cleared, advanced by a 6-bit amount, or held. Instruction decode and the arithmetic unit lie outside this block.

Top module: `wrf_top`

## Requirements
- R1: A synchronous active-high reset sets the window pointer `wp_o` to 0. Register contents stay undefined until they are written.
- R2: With `wp_op_i` = 2'b01 (clear), `wp_o` is 0 after the clock edge.
- R3: With `wp_op_i` = 2'b10 (add), `wp_o` becomes (old `wp_o` + `wp_delta_i`) mod 64 after the clock edge.
- R4: With `wp_op_i` = 2'b00 or 2'b11 (hold), `wp_o` keeps its value whatever `wp_delta_i` is.
- R5: Architectural register k (k = 0..3, the value of a 2-bit select) maps to physical entry (`wp_o` + k) mod 64. A window at 62 therefore puts R2 in entry 0 and R3 in entry 1.
- R6: When `wr_en_i` is high, `wr_data_i` is stored at the clock edge into the entry that `dst_sel_i` names under the pointer value from before that edge, even if the pointer changes at the same edge.
- R7: The reads are combinational. A read of the entry being written in the same cycle returns the old contents, and the new value appears after the edge.
- R8: When `wr_en_i` is low, no entry changes, whatever the data and selects are.
- R9: `dst_data_o` and `src_data_o` show the entries named by `dst_sel_i` and `src_sel_i` at the same time and independently, including when both selects are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the window pointer |
| wp_op_i | input | 2 | Pointer command: 00 hold, 01 clear, 10 add, 11 hold |
| wp_delta_i | input | 6 | Amount added to the pointer on an add command |
| dst_sel_i | input | 2 | Destination register select, R0..R3 |
| src_sel_i | input | 2 | Source register select, R0..R3 |
| wr_en_i | input | 1 | Write the destination register at the clock edge |
| wr_data_i | input | 16 | Write data |
| dst_data_o | output | 16 | Destination register contents |
| src_data_o | output | 16 | Source register contents |
| wp_o | output | 6 | Current window pointer |

## Verification
The bench uses the default parameters: 64 entries of 16 bits and a window of four. At this size it can fill every physical entry through a sliding window. It then places the window at each of the 64 pointer values and reads all sixteen source and destination select pairs, so every wrap of R1 to R3 past entry 63 is checked against an arithmetic model. Directed sequences cover pointer adds that overflow, hold with a nonzero delta, a write that lands on the same edge as a pointer move, and read-during-write on one entry.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    localparam int DEF_DEPTH  = 64;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_WIN    = 4;

    typedef enum logic [1:0] {
        WP_HOLD  = 2'b00,
        WP_CLEAR = 2'b01,
        WP_ADD   = 2'b10,
        WP_KEEP  = 2'b11
    } wp_op_e;

    typedef enum logic [0:0] {
        PORT_DST = 1'b0,
        PORT_SRC = 1'b1
    } rd_port_e;

endpackage

// File: rtl/wrf_window_ptr.sv
module wrf_window_ptr
    import wrf_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  wp_op_e           op,
    input  logic [PTR_W-1:0] delta,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else begin
            unique case (op)
                WP_CLEAR: ptr <= '0;
                WP_ADD:   ptr <= ptr + delta;
                default:  ptr <= ptr;
            endcase
        end
    end

endmodule

// File: rtl/wrf_index_map.sv
module wrf_index_map #(
    parameter int PTR_W = 6,
    parameter int SEL_W = 2
) (
    input  logic [PTR_W-1:0] base,
    input  logic [SEL_W-1:0] sel,
    output logic [PTR_W-1:0] phys
);

    localparam int PAD_W = PTR_W - SEL_W;

    // Pointer-width addition wraps modulo the store depth.
    assign phys = base + {{PAD_W{1'b0}}, sel};

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    parameter int NRD    = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NRD-1:0][ADDR_W-1:0] raddr,
    output logic [NRD-1:0][DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int DATA_W = DEF_DATA_W,
    parameter int WIN    = DEF_WIN,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SEL_W = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wp_op_i,
    input  logic [PTR_W-1:0]  wp_delta_i,
    input  logic [SEL_W-1:0]  dst_sel_i,
    input  logic [SEL_W-1:0]  src_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] dst_data_o,
    output logic [DATA_W-1:0] src_data_o,
    output logic [PTR_W-1:0]  wp_o
);

    localparam int NRD = 2;

    logic [PTR_W-1:0]             win_base;
    logic [NRD-1:0][SEL_W-1:0]    port_sel;
    logic [NRD-1:0][PTR_W-1:0]    port_phys;
    logic [NRD-1:0][DATA_W-1:0]   port_data;

    wrf_window_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (wp_op_e'(wp_op_i)),
        .delta (wp_delta_i),
        .ptr   (win_base)
    );

    assign port_sel[PORT_DST] = dst_sel_i;
    assign port_sel[PORT_SRC] = src_sel_i;

    for (genvar g = 0; g < NRD; g++) begin : g_map
        wrf_index_map #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_map (
            .base (win_base),
            .sel  (port_sel[g]),
            .phys (port_phys[g])
        );
    end

    // The write shares the destination index, which uses the pre-edge pointer.
    wrf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NRD(NRD)) u_store (
        .clk   (clk),
        .we    (wr_en_i),
        .waddr (port_phys[PORT_DST]),
        .wdata (wr_data_i),
        .raddr (port_phys),
        .rdata (port_data)
    );

    assign dst_data_o = port_data[PORT_DST];
    assign src_data_o = port_data[PORT_SRC];
    assign wp_o       = win_base;

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
    parameter int DATA_W = 16,
    parameter int PTR_W  = 6,
    parameter int SEL_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        wp_op_i,
    input logic [PTR_W-1:0]  wp_delta_i,
    input logic [SEL_W-1:0]  dst_sel_i,
    input logic [SEL_W-1:0]  src_sel_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] src_data_o,
    input logic [PTR_W-1:0]  wp_o
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
            assert_reset_ptr_R1: assert (wp_o == '0)
                else $error("window pointer not zero after reset");
        end
    end

    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (wp_op_i == 2'b01) |=> (wp_o == '0));

    assert_add_R3: assert property (@(posedge clk) disable iff (rst)
        (wp_op_i == 2'b10) |=> (wp_o == PTR_W'($past(wp_o) + $past(wp_delta_i))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((wp_op_i == 2'b00) || (wp_op_i == 2'b11)) |=> $stable(wp_o));

    assert_write_visible_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && (wp_op_i == 2'b00)) |=>
            ((src_sel_i != $past(dst_sel_i)) || (src_data_o == $past(wr_data_i))));

endmodule

bind wrf_top wrf_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wp_op_i    (wp_op_i),
    .wp_delta_i (wp_delta_i),
    .dst_sel_i  (dst_sel_i),
    .src_sel_i  (src_sel_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .src_data_o (src_data_o),
    .wp_o       (wp_o)
);

// File: tb/wrf_top_tb_top.sv
`timescale 1ns/1ps
module wrf_top_tb_top;

    localparam int DEPTH  = 64;
    localparam int DATA_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wp_op_i = 2'b00;
    logic [5:0]  wp_delta_i = '0;
    logic [1:0]  dst_sel_i = '0;
    logic [1:0]  src_sel_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] dst_data_o;
    logic [15:0] src_data_o;
    logic [5:0]  wp_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] model [DEPTH];
    int          mptr = 0;

    always #5 clk = ~clk;

    wrf_top dut_i (
        .clk(clk), .rst(rst), .wp_op_i(wp_op_i), .wp_delta_i(wp_delta_i),
        .dst_sel_i(dst_sel_i), .src_sel_i(src_sel_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .dst_data_o(dst_data_o), .src_data_o(src_data_o),
        .wp_o(wp_o)
    );

    function automatic logic [15:0] pat(int p);
        return 16'((p * 1237) ^ 16'hC3A5);
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ptr_cmd(logic [1:0] op, int d);
        wp_op_i = op;
        wp_delta_i = 6'(d);
        step();
        if (op == 2'b01) mptr = 0;
        else if (op == 2'b10) mptr = (mptr + d) % DEPTH;
        wp_op_i = 2'b00;
        wp_delta_i = '0;
    endtask

    task automatic set_wp(int w);
        ptr_cmd(2'b01, 0);
        ptr_cmd(2'b10, w);
    endtask

    task automatic wr(int sel, logic [15:0] d);
        dst_sel_i = 2'(sel);
        wr_data_i = d;
        wr_en_i = 1'b1;
        step();
        model[(mptr + sel) % DEPTH] = d;
        wr_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R1: pointer is zero after reset
        check("R1 reset pointer", 16'(wp_o), 16'd0);

        // Fill every physical entry through a sliding window (R6)
        for (int b = 0; b < DEPTH; b += 4) begin
            set_wp(b);
            for (int k = 0; k < 4; k++) wr(k, pat(b + k));
        end

        // R5 / R9: every pointer value, every select pair
        for (int w = 0; w < DEPTH; w++) begin
            set_wp(w);
            check("R3 pointer after add", 16'(wp_o), 16'(w));
            for (int d = 0; d < 4; d++) begin
                for (int s = 0; s < 4; s++) begin
                    dst_sel_i = 2'(d);
                    src_sel_i = 2'(s);
                    #1;
                    check("R5 dst mapping", dst_data_o, pat((w + d) % DEPTH));
                    check("R9 src mapping", src_data_o, pat((w + s) % DEPTH));
                end
            end
        end

        // R5 explicit wrap: window at 62, R2 -> entry 0, R3 -> entry 1
        set_wp(62);
        dst_sel_i = 2'd2; src_sel_i = 2'd3; #1;
        check("R5 wrap R2", dst_data_o, pat(0));
        check("R5 wrap R3", src_data_o, pat(1));

        // R3: accumulating adds with overflow
        set_wp(0);
        for (int i = 0; i < 20; i++) begin
            ptr_cmd(2'b10, (i * 13 + 7) % 64);
            check("R3 add modulo", 16'(wp_o), 16'(mptr));
        end
        ptr_cmd(2'b10, 63);
        check("R3 add 63", 16'(wp_o), 16'(mptr));

        // R4: hold with nonzero delta, both hold codes
        for (int i = 0; i < 4; i++) begin
            wp_op_i = (i % 2 == 0) ? 2'b00 : 2'b11;
            wp_delta_i = 6'(5 + i);
            step();
            check("R4 hold", 16'(wp_o), 16'(mptr));
        end
        wp_op_i = 2'b00; wp_delta_i = '0;

        // R2: clear from nonzero
        set_wp(41);
        ptr_cmd(2'b01, 0);
        check("R2 clear", 16'(wp_o), 16'd0);

        // R6: write and pointer add on the same edge use the old pointer
        set_wp(10);
        dst_sel_i = 2'd1; wr_data_i = 16'hBEEF; wr_en_i = 1'b1;
        wp_op_i = 2'b10; wp_delta_i = 6'd5;
        step();
        wr_en_i = 1'b0; wp_op_i = 2'b00; wp_delta_i = '0;
        model[11] = 16'hBEEF; mptr = 15;
        check("R6 pointer moved", 16'(wp_o), 16'd15);
        src_sel_i = 2'd1; #1;
        check("R6 new window entry untouched", src_data_o, model[16]);
        set_wp(10);
        src_sel_i = 2'd1; #1;
        check("R6 write used old pointer", src_data_o, 16'hBEEF);

        // R7: read during write returns old, then new
        set_wp(30);
        dst_sel_i = 2'd2; src_sel_i = 2'd2;
        wr_data_i = 16'h1234; wr_en_i = 1'b1; #1;
        check("R7 old during write dst", dst_data_o, model[32]);
        check("R7 old during write src", src_data_o, model[32]);
        step();
        model[32] = 16'h1234; wr_en_i = 1'b0;
        check("R7 new after edge", src_data_o, 16'h1234);

        // R8: disabled write changes nothing in the window
        wr_en_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            dst_sel_i = 2'(k); wr_data_i = 16'hDEAD; step();
        end
        for (int k = 0; k < 4; k++) begin
            src_sel_i = 2'(k); #1;
            check("R8 no write when disabled", src_data_o, model[(30 + k) % DEPTH]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule